// File: doc/BRIEF.md
# Infrared Transmit Pulse Encoder

This block sits after the serial output of a UART transmitter and turns each bit of the transmit stream into the drive signal for an infrared LED. A space bit (logic zero) becomes one short high pulse at the start of its bit cell. A mark bit (logic one), including an idle line, leaves the LED dark. The block runs on the crystal clock. It is given a one-clock enable at sixteen times the bit rate. It counts its own bit cells from reset: each cell is sixteen enables long, and the enable that completes a cell marks the bit boundary. The transmitter must present the next bit on `txData` by that boundary cycle.

The pulse width comes from an 8-bit write-only register. A value of zero selects the default width of three 16x enable periods, which is 3/16 of a bit. A nonzero value N selects a pulse of exactly N crystal clocks. Short pulses cut LED on-time and save power. The block measures the length of every bit cell in crystal clocks. A programmed width that would fill the whole cell is illegal. In that case the block raises a sticky error flag and stops emitting pulses until software writes the register again. A written value is held and takes effect at the next bit boundary, so the pulse in flight keeps its width.

Top module: `ir_pulse_encoder`

## Requirements
- R1: After reset `irOut` and `cfgErr` are low, and the width register holds 0, which selects the default width.
- R2: A pulse rises in the first clock after the boundary edge. The boundary edge is the clock edge carrying the 16x enable that closes a cell; cells are 16 enables long, counted from reset. `txData` is sampled in that same boundary cycle.
- R3: A sampled value of 1 on `txData` produces no pulse, and `irOut` stays low for the whole cell.
- R4: With width register 0, the pulse lasts exactly three 16x enable periods. It falls on the edge of the third enable after the boundary.
- R5: With width register N (1 to 255), the pulse lasts exactly N clocks.
- R6: At a boundary, a nonzero width N is illegal if N is at least the number of clocks in the cell that just ended. An illegal width sets `cfgErr`, and while `cfgErr` is high `irOut` stays low and no pulse starts. A width of one clock less than the cell length is legal.
- R7: `cfgErr` stays high until a register write. A write clears it on the write's own clock edge.
- R8: A register write outside a boundary cycle is held until the next boundary. A pulse already in progress keeps the width it started with.
- R9: A write in the boundary cycle itself applies to that boundary. If the written value is illegal, `cfgErr` is set or stays set, and the set overrides the clearing effect of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock enable at 16x the bit rate |
| txData | input | 1 | Serial transmit bit, 0 = space |
| pwWrEn | input | 1 | Write strobe for the width register |
| pwWrData | input | PW_W | Value written to the width register |
| irOut | output | 1 | LED drive, high during a pulse |
| cfgErr | output | 1 | Sticky flag for an illegal programmed width |

## Verification
A register write and a bit boundary can land in the same clock. In that cycle, the clearing of the error flag by the write competes with the legality check of the boundary. The pulse that starts there must also use the freshly written width rather than the held one. The bench watches the 16x enables it drives itself and puts a write on the exact cycle of the sixteenth enable. It does this twice with the error flag already set: once with an illegal value, which must leave `cfgErr` high with no pulse, and once with a legal 7, which must clear `cfgErr` and yield a 7-clock pulse in that same cell.

// File: rtl/irenc_pkg.sv
package irenc_pkg;
  // Strobes from the control section to the pulse datapath
  typedef struct packed {
    logic start;     // begin a pulse this edge
    logic useTicks;  // pulse timed in 16x enables rather than clocks
    logic tickEnd;   // enable that closes a default-width pulse
    logic cellEnd;   // bit boundary
    logic halt;      // error flag holds the output low
  } irStrb_t;
endpackage

// File: rtl/irenc_ctrl.sv
module irenc_ctrl
  import irenc_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DEF_TICKS     = 3,
  parameter int PW_W          = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick16,
  input  logic            txData,
  input  logic            pwWrEn,
  input  logic [PW_W-1:0] pwWrData,
  output irStrb_t         strb,
  output logic [PW_W-1:0] width,
  output logic            cfgErr
);
  localparam int PH_W  = $clog2(TICKS_PER_BIT);
  localparam int LEN_W = PW_W + 1;
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(TICKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] END_PH  = PH_W'(DEF_TICKS - 1);

  logic [PH_W-1:0]  phase;
  logic [LEN_W-1:0] lenCnt, cellLen;
  logic [PW_W-1:0]  pwPend, nextPw;
  logic             bnd, overLimit, errFlag, errNext;

  always_comb begin
    bnd       = tick16 && (phase == LAST_PH);
    // a write in the boundary cycle is forwarded to that boundary
    nextPw    = pwWrEn ? pwWrData : pwPend;
    cellLen   = (&lenCnt) ? lenCnt : lenCnt + 1'b1;
    overLimit = (nextPw != '0) && ({1'b0, nextPw} >= cellLen);
    // set at a boundary wins over the clear from a write
    errNext   = (bnd && overLimit) || (errFlag && !pwWrEn);
    strb.start    = bnd && !txData && !errNext;
    strb.useTicks = (nextPw == '0);
    strb.tickEnd  = tick16 && (phase == END_PH);
    strb.cellEnd  = bnd;
    strb.halt     = errFlag;
    width  = nextPw;
    cfgErr = errFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      lenCnt  <= '0;
      pwPend  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (tick16) phase <= bnd ? '0 : phase + 1'b1;
      lenCnt  <= bnd ? '0 : cellLen;
      if (pwWrEn) pwPend <= pwWrData;
      errFlag <= errNext;
    end
  end
endmodule

// File: rtl/irenc_datapath.sv
module irenc_datapath
  import irenc_pkg::*;
#(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  irStrb_t         strb,
  input  logic [PW_W-1:0] width,
  output logic            irOut
);
  logic [PW_W-1:0] cnt;
  logic            tickMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irOut    <= 1'b0;
      cnt      <= '0;
      tickMode <= 1'b0;
    end else if (strb.start) begin
      irOut    <= 1'b1;
      tickMode <= strb.useTicks;
      cnt      <= width;
    end else if (strb.cellEnd || strb.halt) begin
      irOut <= 1'b0;
    end else if (irOut) begin
      if (tickMode) begin
        if (strb.tickEnd) irOut <= 1'b0;
      end else begin
        if (cnt == PW_W'(1)) irOut <= 1'b0;
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_pulse_encoder.sv
module ir_pulse_encoder
  import irenc_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DEF_TICKS     = 3,
  parameter int PW_W          = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick16,
  input  logic            txData,
  input  logic            pwWrEn,
  input  logic [PW_W-1:0] pwWrData,
  output logic            irOut,
  output logic            cfgErr
);
  irStrb_t         strb;
  logic [PW_W-1:0] width;

  irenc_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DEF_TICKS    (DEF_TICKS),
    .PW_W         (PW_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick16  (tick16),
    .txData  (txData),
    .pwWrEn  (pwWrEn),
    .pwWrData(pwWrData),
    .strb    (strb),
    .width   (width),
    .cfgErr  (cfgErr)
  );

  irenc_datapath #(.PW_W(PW_W)) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .width(width),
    .irOut(irOut)
  );
endmodule

// File: rtl/ir_pulse_encoder_chk.sv
module ir_pulse_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic tick16,
  input logic txData,
  input logic pwWrEn,
  input logic irOut,
  input logic cfgErr
);
  // R6
  ir_low_when_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !irOut);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !pwWrEn) |=> cfgErr);
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgErr) |-> $past(pwWrEn));
  // R3
  rise_on_space_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irOut) |-> !$past(txData));
  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irOut) |-> $past(tick16));
endmodule

bind ir_pulse_encoder ir_pulse_encoder_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .tick16(tick16),
  .txData(txData),
  .pwWrEn(pwWrEn),
  .irOut (irOut),
  .cfgErr(cfgErr)
);

// File: tb/ir_pulse_encoder_tb_top.sv
module ir_pulse_encoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int TPB        = 16;
  localparam int CELL       = TICK_DIV * TPB;

  logic       clk = 1'b0, rstN = 1'b0, tick16 = 1'b0, txData = 1'b1, pwWrEn = 1'b0;
  logic [7:0] pwWrData = '0;
  logic       irOut, cfgErr;
  int checks = 0, fails = 0, tickIdx = 0, bndCnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_pulse_encoder dut_i (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txData(txData),
    .pwWrEn(pwWrEn), .pwWrData(pwWrData), .irOut(irOut), .cfgErr(cfgErr)
  );

  initial begin : tickGen
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      tick16 = (c == TICK_DIV - 1);
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
    end
  end

  // bench view of bit boundaries, from the enables it drives
  always @(posedge clk) begin
    if (rstN && tick16) begin
      if (tickIdx % TPB == TPB - 1) bndCnt <= bndCnt + 1;
      tickIdx <= tickIdx + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepNeg();
    @(negedge clk); #1;
  endtask

  task automatic waitBnd();
    int c;
    c = bndCnt;
    while (bndCnt == c) stepNeg();
  endtask

  task automatic waitBndCycle();
    stepNeg();
    while (!(tick16 && (tickIdx % TPB == TPB - 1))) stepNeg();
  endtask

  task automatic writePw(input logic [7:0] v);
    pwWrEn = 1'b1; pwWrData = v;
    stepNeg();
    pwWrEn = 1'b0;
  endtask

  task automatic runCell(input logic b, output int w, output int first);
    waitBnd();
    txData = b;
    waitBnd();
    first = irOut;
    w = 0;
    for (int i = 0; i < CELL; i++) begin
      if (irOut) w++;
      stepNeg();
    end
  endtask

  task automatic collide(input logic [7:0] v, input int expErr, input int expW, input string tag);
    int w;
    waitBndCycle();
    pwWrEn = 1'b1; pwWrData = v; txData = 1'b0;
    stepNeg();
    pwWrEn = 1'b0;
    check({tag, " cfgErr after boundary write"}, cfgErr, expErr);
    w = 0;
    for (int i = 0; i < CELL; i++) begin
      if (irOut) w++;
      stepNeg();
    end
    check({tag, " pulse width"}, w, expW);
  endtask

  task automatic tReset();
    check("R1 irOut after reset", irOut, 0);
    check("R1 cfgErr after reset", cfgErr, 0);
  endtask

  task automatic tDefault();
    int w, f;
    runCell(1'b0, w, f);
    check("R4 default width", w, 3 * TICK_DIV);
    check("R2 pulse high in first clock of cell", f, 1);
  endtask

  task automatic tMark();
    int w, f;
    runCell(1'b1, w, f);
    check("R3 mark bit gives no pulse", w, 0);
  endtask

  task automatic tProgrammed();
    int w, f;
    writePw(8'd5);
    runCell(1'b0, w, f);
    check("R5 width 5", w, 5);
    writePw(8'd1);
    runCell(1'b0, w, f);
    check("R5 width 1", w, 1);
    writePw(8'(CELL - 1));
    runCell(1'b0, w, f);
    check("R6 width one below cell is legal", w, CELL - 1);
    check("R6 no error for legal width", cfgErr, 0);
  endtask

  task automatic tError();
    int w, f;
    writePw(8'(CELL));
    runCell(1'b0, w, f);
    check("R6 illegal width suppresses pulse", w, 0);
    check("R6 illegal width raises cfgErr", cfgErr, 1);
    runCell(1'b0, w, f);
    check("R7 still no pulse while flagged", w, 0);
    check("R7 cfgErr sticky", cfgErr, 1);
    writePw(8'd0);
    check("R7 write clears cfgErr", cfgErr, 0);
    runCell(1'b0, w, f);
    check("R7 default pulse after clear", w, 3 * TICK_DIV);
  endtask

  task automatic tMidWrite();
    int w, f;
    writePw(8'd40);
    runCell(1'b0, w, f);
    check("R5 width 40", w, 40);
    waitBnd();
    txData = 1'b0;
    waitBnd();
    w = 0;
    for (int i = 0; i < CELL; i++) begin
      if (irOut) w++;
      pwWrEn = (i == 5);
      pwWrData = 8'd10;
      stepNeg();
    end
    pwWrEn = 1'b0;
    check("R8 pulse in flight keeps width", w, 40);
    runCell(1'b0, w, f);
    check("R8 new width at next boundary", w, 10);
  endtask

  task automatic tCollision();
    int w, f;
    writePw(8'd100);
    runCell(1'b0, w, f);
    check("R9 setup error raised", cfgErr, 1);
    collide(8'd200, 1, 0, "R9 illegal write at boundary");
    collide(8'd7, 0, 7, "R9 legal write at boundary");
  endtask

  initial begin
    repeat (3) stepNeg();
    rstN = 1'b1;
    stepNeg();
    tReset();
    tDefault();
    tMark();
    tProgrammed();
    tError();
    tMidWrite();
    tCollision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule